// File: doc/BRIEF.md
# Interrupt Critical Section Controller

This block sequences exception entry and return for a small in-order core. It holds one interrupt-critical flag for each privilege level, a saved-return-PC register and a saved-status register. When the flag of the running level is set, it holds back asynchronous interrupts. Interrupt requests arrive as one-cycle pulses and are latched as pending. Synchronous faults, a decoded interrupt-return strobe and special-register writes arrive from the pipeline. The block answers in the same cycle with a PC redirect, an acknowledge, and double-fault or protection-violation pulses. Its state changes at the next clock edge.

Any entry, whether an interrupt or a fault, moves the core to the highest privilege level and raises that level's flag. This gives the handler a window in which it can read the saved context without being interrupted. Interrupt return jumps to the saved PC and reloads the flag of level 0 in the same step. Only a saved status word of exactly 0 or 1 is accepted as a legal return.

Top module: `ics_ctrl`

## Requirements
- R1: After reset the privilege level is NUM_PL-1, the flag of that level is 1, no interrupt is pending, both context registers are 0 and no redirect is driven.
- R2: A pulse on an `irq_raise` bit stays pending from the next edge until it is acknowledged. When several are pending, the lowest-numbered one is served first, and `irq_ack` is one-hot.
- R3: While the flag of the current level is 1, no interrupt is acknowledged and pending requests are kept.
- R4: Interrupt i is taken when one is pending and the current flag is 0. In that cycle the redirect goes to VEC_BASE + i*VEC_STRIDE. At the edge the saved PC becomes `cur_pc` and the saved status becomes {level, flag} (flag in bit 0, old level in bits above it). The level then becomes NUM_PL-1 and its flag becomes 1.
- R5: A synchronous fault while the current flag is 0 is a normal entry. The vector is VEC_BASE + NUM_IRQ*VEC_STRIDE, and the context is saved as in R4.
- R6: A synchronous fault while the current flag is 1 pulses `dbl_fault` and redirects to VEC_BASE + (NUM_IRQ+1)*VEC_STRIDE. Both context registers are left unchanged, and the level and flag become NUM_PL-1 and 1.
- R7: Interrupt return with a saved status of 0 or 1 redirects to the saved PC in the same cycle. At the edge the level becomes 0 and the level-0 flag takes bit 0 of the saved status.
- R8: Interrupt return with any other saved status pulses `gpv_trap`, drives no redirect and changes no state.
- R9: Every level has its own flag, and only the flag of the current level gates interrupts and picks a double fault.
- R10: Special-register writes use `spr_sel` 0 for the saved PC, 1 for the saved status and 2 for the current level's flag (from bit 0). A write in a cycle with a fault, an interrupt entry or an interrupt return is dropped and `spr_retry` is raised.
- R11: Events in the same cycle are ranked as follows: fault first, then interrupt entry, then interrupt return, then the register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | XLEN | PC of the instruction at the exception point |
| irq_raise | input | NUM_IRQ | Interrupt request pulses |
| sync_fault | input | 1 | Synchronous fault from the pipeline |
| eret_valid | input | 1 | Decoded interrupt-return strobe |
| spr_we | input | 1 | Special-register write strobe |
| spr_sel | input | 2 | Write target: 0 saved PC, 1 saved status, 2 flag |
| spr_wdata | input | XLEN | Write data |
| redirect_valid | output | 1 | Next-PC redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| irq_ack | output | NUM_IRQ | One-hot acknowledge of the interrupt taken |
| dbl_fault | output | 1 | Double-fault pulse |
| gpv_trap | output | 1 | Protection-violation pulse on an illegal return |
| spr_retry | output | 1 | Write dropped; the pipeline must retry it |
| priv_o | output | $clog2(NUM_PL) | Current privilege level |
| crit_o | output | 1 | Flag of the current level |
| ctx_pc_o | output | XLEN | Saved return PC |
| ctx_stat_o | output | XLEN | Saved status word |

## Verification
The bench raises an interrupt while the flag is set and then clears the flag. A design that ignores the flag would acknowledge too early, and one that drops deferred requests would never enter. It returns into level 0 with the restored flag set and then faults there. A design that gates on the wrong level's flag would take a normal fault instead of a double fault. It also returns with saved status values 2 and 3, which must give a violation with no branch, and issues a fault together with a pending interrupt, and a register write together with an entry. A design that ranks these wrongly would redirect to the wrong vector or corrupt the saved PC.

// File: rtl/ics_pkg.sv
package ics_pkg;
   typedef enum logic [1:0] {
      SPR_CTX_PC   = 2'd0,
      SPR_CTX_STAT = 2'd1,
      SPR_CRIT     = 2'd2
   } spr_sel_e;

   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_FAULT = 2'd1,
      EV_IRQ   = 2'd2,
      EV_ERET  = 2'd3
   } event_e;
endpackage

// File: rtl/ics_pend.sv
module ics_pend #(
   parameter int unsigned NUM_IRQ = 8,
   localparam int unsigned IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] raise_i,
   input  logic               take_i,
   output logic               any_o,
   output logic [IW-1:0]      idx_o,
   output logic [NUM_IRQ-1:0] ack_o
);
   logic [NUM_IRQ-1:0] pend_q;
   logic [NUM_IRQ-1:0] first_oh;

   always_comb begin
      first_oh = '0;
      idx_o    = '0;
      for (int k = NUM_IRQ - 1; k >= 0; k--) begin
         if (pend_q[k]) begin
            first_oh = '0;
            first_oh[k] = 1'b1;
            idx_o = IW'(k);
         end
      end
   end

   assign any_o = |pend_q;
   assign ack_o = take_i ? first_oh : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~ack_o) | raise_i;
   end

   a_r2_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o));
   a_r2_ack_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_o) |-> ((ack_o & pend_q) != '0));
endmodule

// File: rtl/ics_flags.sv
module ics_flags #(
   parameter int unsigned NUM_PL = 4,
   localparam int unsigned PLW = $clog2(NUM_PL),
   localparam int unsigned TOP = NUM_PL - 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [PLW-1:0] pl_i,
   input  logic           set_top_i,
   input  logic           ld0_en_i,
   input  logic           ld0_val_i,
   input  logic           wr_en_i,
   input  logic           wr_val_i,
   output logic           cur_o
);
   logic [NUM_PL-1:0] flag_q;

   for (genvar g = 0; g < NUM_PL; g++) begin : g_lvl
      if (g == TOP) begin : g_top
         always_ff @(posedge clk) begin
            if (!rst_n)                          flag_q[g] <= 1'b1;
            else if (set_top_i)                  flag_q[g] <= 1'b1;
            else if (wr_en_i && pl_i == PLW'(g)) flag_q[g] <= wr_val_i;
         end
      end else if (g == 0) begin : g_zero
         always_ff @(posedge clk) begin
            if (!rst_n)                          flag_q[g] <= 1'b0;
            else if (ld0_en_i)                   flag_q[g] <= ld0_val_i;
            else if (wr_en_i && pl_i == PLW'(g)) flag_q[g] <= wr_val_i;
         end
      end else begin : g_mid
         always_ff @(posedge clk) begin
            if (!rst_n)                          flag_q[g] <= 1'b0;
            else if (wr_en_i && pl_i == PLW'(g)) flag_q[g] <= wr_val_i;
         end
      end
   end

   assign cur_o = flag_q[pl_i];

   a_r4_top_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_top_i |=> flag_q[TOP]);
endmodule

// File: rtl/ics_ctx.sv
module ics_ctx #(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            save_i,
   input  logic [XLEN-1:0] save_pc_i,
   input  logic [XLEN-1:0] save_stat_i,
   input  logic            wr_pc_i,
   input  logic            wr_stat_i,
   input  logic [XLEN-1:0] wdata_i,
   output logic [XLEN-1:0] pc_o,
   output logic [XLEN-1:0] stat_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_o   <= '0;
         stat_o <= '0;
      end else if (save_i) begin
         pc_o   <= save_pc_i;
         stat_o <= save_stat_i;
      end else begin
         if (wr_pc_i)   pc_o   <= wdata_i;
         if (wr_stat_i) stat_o <= wdata_i;
      end
   end

   a_r10_no_double_write: assert property (@(posedge clk) disable iff (!rst_n)
      save_i |-> !(wr_pc_i || wr_stat_i));
endmodule

// File: rtl/ics_ctrl.sv
module ics_ctrl
   import ics_pkg::*;
#(
   parameter int unsigned    XLEN       = 32,
   parameter int unsigned    NUM_PL     = 4,
   parameter int unsigned    NUM_IRQ    = 8,
   parameter logic [31:0]    VEC_BASE   = 32'h0000_1000,
   parameter logic [31:0]    VEC_STRIDE = 32'h0000_0040
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [XLEN-1:0]           cur_pc,
   input  logic [NUM_IRQ-1:0]        irq_raise,
   input  logic                      sync_fault,
   input  logic                      eret_valid,
   input  logic                      spr_we,
   input  logic [1:0]                spr_sel,
   input  logic [XLEN-1:0]           spr_wdata,
   output logic                      redirect_valid,
   output logic [XLEN-1:0]           redirect_pc,
   output logic [NUM_IRQ-1:0]        irq_ack,
   output logic                      dbl_fault,
   output logic                      gpv_trap,
   output logic                      spr_retry,
   output logic [$clog2(NUM_PL)-1:0] priv_o,
   output logic                      crit_o,
   output logic [XLEN-1:0]           ctx_pc_o,
   output logic [XLEN-1:0]           ctx_stat_o
);
   localparam int unsigned PLW = $clog2(NUM_PL);
   localparam int unsigned IW  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
   localparam logic [PLW-1:0] TOP_PL = PLW'(NUM_PL - 1);
   localparam logic [XLEN-1:0] BASE   = XLEN'(VEC_BASE);
   localparam logic [XLEN-1:0] STRIDE = XLEN'(VEC_STRIDE);
   localparam logic [XLEN-1:0] FAULT_VEC = BASE + XLEN'(NUM_IRQ) * STRIDE;
   localparam logic [XLEN-1:0] DBL_VEC   = BASE + XLEN'(NUM_IRQ + 1) * STRIDE;

   if (NUM_PL < 2) begin : g_bad_pl
      $error("ics_ctrl: NUM_PL must be at least 2");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > 64) begin : g_bad_irq
      $error("ics_ctrl: NUM_IRQ must be 1..64");
   end
   if (XLEN < PLW + 2) begin : g_bad_xlen
      $error("ics_ctrl: XLEN too narrow for the status word");
   end

   logic [PLW-1:0] pl_q;
   logic           crit_cur;
   logic           pend_any;
   logic [IW-1:0]  pend_idx;
   logic           take_irq;
   logic           eret_ok;
   logic           spr_do;
   logic           fault_dbl;
   logic [XLEN-1:0] old_stat;
   event_e         ev;

   // event ranking: fault, interrupt entry, interrupt return
   always_comb begin
      if (sync_fault)                  ev = EV_FAULT;
      else if (pend_any && !crit_cur)  ev = EV_IRQ;
      else if (eret_valid)             ev = EV_ERET;
      else                             ev = EV_NONE;
   end

   assign take_irq  = (ev == EV_IRQ);
   assign fault_dbl = (ev == EV_FAULT) && crit_cur;
   assign eret_ok   = (ctx_stat_o == XLEN'(0)) || (ctx_stat_o == XLEN'(1));
   assign spr_do    = spr_we && (ev == EV_NONE);
   assign spr_retry = spr_we && (ev != EV_NONE);
   assign old_stat  = {{(XLEN-PLW-1){1'b0}}, pl_q, crit_cur};

   ics_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .raise_i (irq_raise),
      .take_i  (take_irq),
      .any_o   (pend_any),
      .idx_o   (pend_idx),
      .ack_o   (irq_ack)
   );

   ics_flags #(.NUM_PL(NUM_PL)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .pl_i      (pl_q),
      .set_top_i (ev == EV_FAULT || take_irq),
      .ld0_en_i  (ev == EV_ERET && eret_ok),
      .ld0_val_i (ctx_stat_o[0]),
      .wr_en_i   (spr_do && spr_sel == SPR_CRIT),
      .wr_val_i  (spr_wdata[0]),
      .cur_o     (crit_cur)
   );

   ics_ctx #(.XLEN(XLEN)) u_ctx (
      .clk         (clk),
      .rst_n       (rst_n),
      .save_i      (take_irq || (ev == EV_FAULT && !crit_cur)),
      .save_pc_i   (cur_pc),
      .save_stat_i (old_stat),
      .wr_pc_i     (spr_do && spr_sel == SPR_CTX_PC),
      .wr_stat_i   (spr_do && spr_sel == SPR_CTX_STAT),
      .wdata_i     (spr_wdata),
      .pc_o        (ctx_pc_o),
      .stat_o      (ctx_stat_o)
   );

   always_comb begin
      redirect_valid = 1'b0;
      redirect_pc    = '0;
      dbl_fault      = 1'b0;
      gpv_trap       = 1'b0;
      unique case (ev)
         EV_FAULT: begin
            redirect_valid = 1'b1;
            redirect_pc    = fault_dbl ? DBL_VEC : FAULT_VEC;
            dbl_fault      = fault_dbl;
         end
         EV_IRQ: begin
            redirect_valid = 1'b1;
            redirect_pc    = BASE + XLEN'(pend_idx) * STRIDE;
         end
         EV_ERET: begin
            redirect_valid = eret_ok;
            redirect_pc    = eret_ok ? ctx_pc_o : '0;
            gpv_trap       = !eret_ok;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                         pl_q <= TOP_PL;
      else if (ev == EV_FAULT || take_irq) pl_q <= TOP_PL;
      else if (ev == EV_ERET && eret_ok)  pl_q <= '0;
   end

   assign priv_o = pl_q;
   assign crit_o = crit_cur;

   a_r3_defer: assert property (@(posedge clk) disable iff (!rst_n)
      crit_o |-> (irq_ack == '0));
   a_r4_entry_top: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |=> (crit_o && priv_o == TOP_PL));
   a_r6_double: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_fault && crit_o) |-> (dbl_fault && redirect_pc == DBL_VEC));
   a_r6_ctx_kept: assert property (@(posedge clk) disable iff (!rst_n)
      dbl_fault |=> ($stable(ctx_pc_o) && $stable(ctx_stat_o)));
   a_r7_return_lvl: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_valid && !sync_fault && irq_ack == '0 && redirect_valid) |=> (priv_o == '0));
   a_r8_gpv_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
      gpv_trap |-> !redirect_valid);
   a_r8_gpv_state: assert property (@(posedge clk) disable iff (!rst_n)
      gpv_trap |=> ($stable(priv_o) && $stable(crit_o)));
   a_r11_fault_first: assert property (@(posedge clk) disable iff (!rst_n)
      sync_fault |-> (irq_ack == '0 && !gpv_trap));
endmodule

// File: tb/sim_ics_ctrl.sv
module sim_ics_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cur_pc = '0;
   logic [7:0]  irq_raise = '0;
   logic        sync_fault = 1'b0;
   logic        eret_valid = 1'b0;
   logic        spr_we = 1'b0;
   logic [1:0]  spr_sel = '0;
   logic [31:0] spr_wdata = '0;
   logic        redirect_valid;
   logic [31:0] redirect_pc;
   logic [7:0]  irq_ack;
   logic        dbl_fault, gpv_trap, spr_retry, crit_o;
   logic [1:0]  priv_o;
   logic [31:0] ctx_pc_o, ctx_stat_o;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   ics_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .irq_raise(irq_raise),
      .sync_fault(sync_fault), .eret_valid(eret_valid), .spr_we(spr_we),
      .spr_sel(spr_sel), .spr_wdata(spr_wdata), .redirect_valid(redirect_valid),
      .redirect_pc(redirect_pc), .irq_ack(irq_ack), .dbl_fault(dbl_fault),
      .gpv_trap(gpv_trap), .spr_retry(spr_retry), .priv_o(priv_o),
      .crit_o(crit_o), .ctx_pc_o(ctx_pc_o), .ctx_stat_o(ctx_stat_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // inputs change just after a falling edge; outputs sampled 2 ns later
   task automatic idle();
      cur_pc = '0; irq_raise = '0; sync_fault = 0; eret_valid = 0;
      spr_we = 0; spr_sel = '0; spr_wdata = '0;
   endtask

   task automatic tick();
      @(negedge clk);
      idle();
      #2;
   endtask

   task automatic spr_write(input logic [1:0] sel, input logic [31:0] d);
      spr_we = 1; spr_sel = sel; spr_wdata = d;
      tick();
   endtask

   task automatic raise(input logic [7:0] m);
      irq_raise = m;
      tick();
   endtask

   task automatic t_reset();
      chk("R1", "priv", 32'(priv_o), 32'd3);
      chk("R1", "crit", 32'(crit_o), 32'd1);
      chk("R1", "redirect", 32'(redirect_valid), 32'd0);
      chk("R1", "ack", 32'(irq_ack), 32'd0);
      chk("R1", "ctx_pc", ctx_pc_o, 32'd0);
      chk("R1", "ctx_stat", ctx_stat_o, 32'd0);
   endtask

   task automatic t_defer_entry();
      raise(8'h04);
      chk("R3", "ack while flag set", 32'(irq_ack), 32'd0);
      chk("R3", "no redirect", 32'(redirect_valid), 32'd0);
      spr_write(2'd2, 32'd0);
      cur_pc = 32'h500; #1;
      chk("R4", "ack irq2", 32'(irq_ack), 32'h04);
      chk("R4", "vector irq2", redirect_pc, 32'h1080);
      tick();
      chk("R4", "ctx_pc", ctx_pc_o, 32'h500);
      chk("R4", "ctx_stat {3,0}", ctx_stat_o, 32'd6);
      chk("R4", "priv top", 32'(priv_o), 32'd3);
      chk("R4", "flag set", 32'(crit_o), 32'd1);
   endtask

   task automatic t_priority();
      raise(8'h22);
      spr_write(2'd2, 32'd0);
      chk("R2", "lowest first", 32'(irq_ack), 32'h02);
      chk("R2", "vector irq1", redirect_pc, 32'h1040);
      tick();
      spr_write(2'd2, 32'd0);
      chk("R2", "second served", 32'(irq_ack), 32'h20);
      chk("R2", "vector irq5", redirect_pc, 32'h1140);
      tick();
      spr_write(2'd2, 32'd0);
      chk("R2", "pending cleared", 32'(redirect_valid), 32'd0);
      spr_write(2'd2, 32'd1);
      chk("R10", "flag written", 32'(crit_o), 32'd1);
   endtask

   task automatic t_double();
      spr_write(2'd0, 32'hAAA0);
      chk("R10", "ctx_pc written", ctx_pc_o, 32'hAAA0);
      sync_fault = 1; cur_pc = 32'h777; #1;
      chk("R6", "dbl pulse", 32'(dbl_fault), 32'd1);
      chk("R6", "dbl vector", redirect_pc, 32'h1240);
      tick();
      chk("R6", "ctx_pc kept", ctx_pc_o, 32'hAAA0);
      chk("R6", "priv", 32'(priv_o), 32'd3);
   endtask

   task automatic t_return_and_fault();
      spr_write(2'd0, 32'h2000);
      spr_write(2'd1, 32'd0);
      eret_valid = 1; #1;
      chk("R7", "redirect", 32'(redirect_valid), 32'd1);
      chk("R7", "target", redirect_pc, 32'h2000);
      tick();
      chk("R7", "priv 0", 32'(priv_o), 32'd0);
      chk("R7", "flag from bit0", 32'(crit_o), 32'd0);
      sync_fault = 1; cur_pc = 32'h2004; #1;
      chk("R5", "no dbl", 32'(dbl_fault), 32'd0);
      chk("R5", "fault vector", redirect_pc, 32'h1200);
      tick();
      chk("R5", "ctx_pc", ctx_pc_o, 32'h2004);
      chk("R5", "ctx_stat", ctx_stat_o, 32'd0);
      chk("R5", "flag set", 32'(crit_o), 32'd1);
   endtask

   task automatic t_levels();
      raise(8'h08);
      chk("R9", "deferred at top", 32'(irq_ack), 32'd0);
      spr_write(2'd0, 32'h3000);
      spr_write(2'd1, 32'd0);
      eret_valid = 1; #1;
      chk("R9", "return wins over deferred irq", redirect_pc, 32'h3000);
      tick();
      cur_pc = 32'h3000; #1;
      chk("R9", "level0 flag gates", 32'(irq_ack), 32'h08);
      chk("R9", "vector irq3", redirect_pc, 32'h10C0);
      tick();
      chk("R4", "saved level0 status", ctx_stat_o, 32'd0);
      chk("R4", "saved pc", ctx_pc_o, 32'h3000);
   endtask

   task automatic t_return_flag1();
      raise(8'h10);
      spr_write(2'd0, 32'h4000);
      spr_write(2'd1, 32'd1);
      eret_valid = 1;
      tick();
      chk("R7", "priv 0", 32'(priv_o), 32'd0);
      chk("R7", "flag restored 1", 32'(crit_o), 32'd1);
      chk("R3", "still deferred", 32'(irq_ack), 32'd0);
      sync_fault = 1; #1;
      chk("R9", "level0 flag -> dbl", 32'(dbl_fault), 32'd1);
      tick();
      spr_write(2'd2, 32'd0);
      chk("R2", "kept pending", 32'(irq_ack), 32'h10);
      tick();
   endtask

   task automatic t_gpv();
      spr_write(2'd0, 32'h5000);
      spr_write(2'd1, 32'd2);
      eret_valid = 1; #1;
      chk("R8", "gpv", 32'(gpv_trap), 32'd1);
      chk("R8", "no branch", 32'(redirect_valid), 32'd0);
      tick();
      chk("R8", "priv kept", 32'(priv_o), 32'd3);
      chk("R8", "flag kept", 32'(crit_o), 32'd1);
      spr_write(2'd1, 32'd3);
      eret_valid = 1; #1;
      chk("R8", "gpv stat 3", 32'(gpv_trap), 32'd1);
      tick();
   endtask

   task automatic t_collide();
      raise(8'h80);
      spr_write(2'd2, 32'd0);
      sync_fault = 1; cur_pc = 32'h900; #1;
      chk("R11", "fault beats irq", redirect_pc, 32'h1200);
      chk("R11", "no ack", 32'(irq_ack), 32'd0);
      tick();
      spr_write(2'd2, 32'd0);
      chk("R11", "irq after fault", 32'(irq_ack), 32'h80);
      tick();
      raise(8'h40);
      spr_write(2'd2, 32'd0);
      cur_pc = 32'h600; spr_we = 1; spr_sel = 2'd0; spr_wdata = 32'hBEEF0; #1;
      chk("R10", "retry", 32'(spr_retry), 32'd1);
      chk("R10", "entry taken", 32'(irq_ack), 32'h40);
      tick();
      chk("R10", "write dropped", ctx_pc_o, 32'h600);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      #2;
      t_reset();
      t_defer_entry();
      t_priority();
      t_double();
      t_return_and_fault();
      t_levels();
      t_return_flag1();
      t_gpv();
      t_collide();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule